// File: doc/BRIEF.md
# Oversampling Serial Receiver with Flagged Two-Entry Buffer

This block recovers asynchronous serial frames from a single data line. It uses an oversampling tick from outside, and its sample timing is realigned to the falling edge that opens each frame. The frame is one start bit, eight data bits sent least significant bit first, an optional parity bit and a stop bit. Each bit value comes from a majority vote of three samples taken around the middle of the bit, so a short spike on the line cannot change the result. The oversample ratio is 16 ticks per bit in normal mode. When the speed control is high it is 8 ticks per bit.

Each completed frame is pushed into a small buffer together with its own frame-error and parity-error flags. The status port always shows the oldest entry. Software reads the status first and then pops the byte through the data port. If a frame completes while the buffer is full, that frame is dropped and a sticky overrun flag is raised. Frames keep being lost until the buffer is read. Dropping the enable aborts any frame in progress and empties the buffer in the next cycle.

Top module: `uart_rx_flagbuf`

## Requirements
- R1: After reset, and whenever the buffer is empty, `stat_valid_o`, `stat_ovr_o`, `stat_frame_o`, `stat_par_o` and `data_o` all read 0.
- R2: A frame is a low start bit, 8 data bits with bit 0 first, and a stop bit. In normal mode (`dbl_spd_i`=0) every bit lasts 16 ticks of `os_tick_i`. Once the frame completes, its byte appears on `data_o` with `stat_valid_o`=1.
- R3: With `dbl_spd_i`=1 every bit lasts 8 ticks, and frames are received in the same way as in R2.
- R4: Each bit is decided by a majority of the samples taken at ticks 7, 8 and 9 of 16 (or 3, 4 and 5 of 8), counted from the tick at which the start bit was seen. A disturbance that covers only one of those samples does not change the bit.
- R5: If the start bit samples high at its middle, the receiver returns to idle and stores nothing.
- R6: `par_mode_i[1]`=1 adds a parity bit after the data bits. `par_mode_i[0]` selects even parity (0) or odd parity (1). When the received parity does not match, `stat_par_o` is 1 for that entry.
- R7: With `par_mode_i[1]`=0 no parity bit is expected, and `stat_par_o` reads 0 for every frame received this way.
- R8: `stat_frame_o` is 1 for an entry exactly when the first stop bit of that frame sampled low. The data byte is still stored.
- R9: The buffer holds two frames in arrival order. The status outputs show the flags of the oldest entry. A `pop_i` pulse while `stat_valid_o`=1 moves on to the next entry. While no pop occurs, the head entry does not change.
- R10: If a frame completes while both entries are full, it is discarded and `stat_ovr_o` becomes 1. The flag stays set, and later frames are also discarded, until a pop, which clears it.
- R11: One cycle after `rx_en_i` goes low, the buffer is empty and all flags are 0. Any partly received frame is abandoned, and the frame received after re-enabling is decoded correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial data line, idle high |
| os_tick_i | input | 1 | Oversample tick, one clock wide |
| rx_en_i | input | 1 | Receiver enable; low aborts and flushes |
| par_mode_i | input | 2 | Bit 1 enables parity, bit 0 selects odd parity |
| dbl_spd_i | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| pop_i | input | 1 | Removes the oldest buffer entry |
| stat_valid_o | output | 1 | Buffer holds at least one entry |
| stat_frame_o | output | 1 | Stop-bit error of the oldest entry |
| stat_par_o | output | 1 | Parity error of the oldest entry |
| stat_ovr_o | output | 1 | Sticky overrun flag |
| data_o | output | DATA_W | Data byte of the oldest entry |

## Verification
The bench builds the block with its default parameters: 8 data bits, a normal ratio of 16, a buffer depth of 2, a two-stage synchroniser and the three-sample vote. With a depth of 2, the third and fourth back-to-back frames reach the overrun path. A tick on every other clock keeps a whole frame short enough that both speed modes, every parity setting and the error injections can all be run in random mixes. A glitch two clocks wide lands on exactly one tick, so it reaches only one of the three voted samples.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_e;

   // two-of-three vote used for noise rejection
   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   initial begin : p_param_chk
      assert (STAGES >= 2) else $error("uart_rx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
   import uart_rx_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int OSR_NORM = 16,
   parameter int MAJORITY = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              tick_i,
   input  logic              rxd_s_i,
   input  logic              par_en_i,
   input  logic              par_odd_i,
   input  logic              dbl_i,
   output logic              done_o,
   output logic [DATA_W-1:0] data_o,
   output logic              ferr_o,
   output logic              perr_o
);

   localparam int CW = $clog2(OSR_NORM);
   localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CW-1:0] TOP_N = CW'(OSR_NORM - 1);
   localparam logic [CW-1:0] TOP_D = CW'(OSR_NORM / 2 - 1);
   localparam logic [CW-1:0] MID_N = CW'(OSR_NORM / 2);
   localparam logic [CW-1:0] MID_D = CW'(OSR_NORM / 4);
   localparam logic [BW-1:0] LAST  = BW'(DATA_W - 1);

   initial begin : p_param_chk
      assert (OSR_NORM >= 8 && (OSR_NORM % 4) == 0)
         else $error("uart_rx_frame: OSR_NORM must be a multiple of 4, at least 8");
      assert (DATA_W >= 2) else $error("uart_rx_frame: DATA_W too small");
   end

   rx_state_e         state_q;
   logic [CW-1:0]     cnt_q;
   logic [BW-1:0]     bidx_q;
   logic              s_a_q, s_b_q;
   logic [DATA_W-1:0] shreg_q;
   logic              pbit_q;
   logic              par_en_q, par_odd_q, dbl_q;
   logic              ferr_q, perr_q, done_q;

   logic [CW-1:0] mid, top, mid_m1, mid_p1;
   logic          vote;

   always_comb begin
      mid    = dbl_q ? MID_D : MID_N;
      top    = dbl_q ? TOP_D : TOP_N;
      mid_m1 = mid - 1'b1;
      mid_p1 = mid + 1'b1;
   end

   generate
      if (MAJORITY != 0) begin : g_vote3
         assign vote = vote3(s_a_q, s_b_q, rxd_s_i);
      end else begin : g_single
         logic unused_a;
         assign unused_a = s_a_q;
         assign vote     = s_b_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         bidx_q    <= '0;
         s_a_q     <= 1'b1;
         s_b_q     <= 1'b1;
         shreg_q   <= '0;
         pbit_q    <= 1'b0;
         par_en_q  <= 1'b0;
         par_odd_q <= 1'b0;
         dbl_q     <= 1'b0;
         ferr_q    <= 1'b0;
         perr_q    <= 1'b0;
         done_q    <= 1'b0;
      end else if (!en_i) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (tick_i) begin
            if (state_q == ST_IDLE) begin
               cnt_q <= '0;
               if (!rxd_s_i) begin
                  state_q   <= ST_START;
                  cnt_q     <= CW'(1);
                  par_en_q  <= par_en_i;
                  par_odd_q <= par_odd_i;
                  dbl_q     <= dbl_i;
               end
            end else begin
               cnt_q <= (cnt_q == top) ? '0 : cnt_q + 1'b1;
               if (cnt_q == mid_m1) s_a_q <= rxd_s_i;
               if (cnt_q == mid)    s_b_q <= rxd_s_i;
               if (cnt_q == mid_p1) begin
                  case (state_q)
                     ST_START: if (vote) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                     end
                     ST_DATA:  shreg_q <= {vote, shreg_q[DATA_W-1:1]};
                     ST_PAR:   pbit_q  <= vote;
                     ST_STOP: begin
                        done_q  <= 1'b1;
                        ferr_q  <= ~vote;
                        perr_q  <= par_en_q & ((^shreg_q) ^ pbit_q ^ par_odd_q);
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                     end
                     default: ;
                  endcase
               end
               if (cnt_q == top) begin
                  case (state_q)
                     ST_START: begin
                        state_q <= ST_DATA;
                        bidx_q  <= '0;
                     end
                     ST_DATA: begin
                        if (bidx_q == LAST) state_q <= par_en_q ? ST_PAR : ST_STOP;
                        else                bidx_q  <= bidx_q + 1'b1;
                     end
                     ST_PAR:  state_q <= ST_STOP;
                     default: ;
                  endcase
               end
            end
         end
      end
   end

   assign done_o = done_q;
   assign data_o = shreg_q;
   assign ferr_o = ferr_q;
   assign perr_o = perr_q;

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
   parameter int WIDTH = 10,
   parameter int DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             push_i,
   input  logic [WIDTH-1:0] din_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] head_o,
   output logic             valid_o,
   output logic             ovr_o
);

   localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int NW  = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] PLAST = AW'(DEPTH - 1);
   localparam logic [NW-1:0] NFULL = NW'(DEPTH);

   initial begin : p_param_chk
      assert (DEPTH >= 1 && DEPTH <= 64) else $error("uart_rx_fifo: DEPTH out of range");
   end

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [AW-1:0]    wp_q, rp_q;
   logic [NW-1:0]    num_q;
   logic             ovr_q;
   logic             full, empty, do_pop, do_push;

   function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
      return (p == PLAST) ? '0 : p + 1'b1;
   endfunction

   assign full    = (num_q == NFULL);
   assign empty   = (num_q == '0);
   assign do_pop  = pop_i & ~empty;
   assign do_push = push_i & (~full | do_pop);

   always_ff @(posedge clk) begin
      if (do_push && !flush_i) mem_q[wp_q] <= din_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         num_q <= '0;
         ovr_q <= 1'b0;
      end else if (flush_i) begin
         wp_q  <= '0;
         rp_q  <= '0;
         num_q <= '0;
         ovr_q <= 1'b0;
      end else begin
         if (do_push) wp_q <= nxt(wp_q);
         if (do_pop)  rp_q <= nxt(rp_q);
         case ({do_push, do_pop})
            2'b10:   num_q <= num_q + 1'b1;
            2'b01:   num_q <= num_q - 1'b1;
            default: ;
         endcase
         if (do_pop)               ovr_q <= 1'b0;
         else if (push_i && full)  ovr_q <= 1'b1;
      end
   end

   assign head_o  = mem_q[rp_q];
   assign valid_o = ~empty;
   assign ovr_o   = ovr_q;

endmodule

// File: rtl/uart_rx_flagbuf.sv
module uart_rx_flagbuf #(
   parameter int DATA_W      = 8,
   parameter int OSR_NORM    = 16,
   parameter int BUF_DEPTH   = 2,
   parameter int SYNC_STAGES = 2,
   parameter int MAJORITY    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd_i,
   input  logic              os_tick_i,
   input  logic              rx_en_i,
   input  logic [1:0]        par_mode_i,
   input  logic              dbl_spd_i,
   input  logic              pop_i,
   output logic              stat_valid_o,
   output logic              stat_frame_o,
   output logic              stat_par_o,
   output logic              stat_ovr_o,
   output logic [DATA_W-1:0] data_o
);

   localparam int EW = DATA_W + 2;

   logic              rxd_s;
   logic              frm_done, frm_ferr, frm_perr;
   logic [DATA_W-1:0] frm_data;
   logic [EW-1:0]     head;
   logic              buf_valid;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rxd_i),
      .q_o   (rxd_s)
   );

   uart_rx_frame #(
      .DATA_W   (DATA_W),
      .OSR_NORM (OSR_NORM),
      .MAJORITY (MAJORITY)
   ) i_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (rx_en_i),
      .tick_i    (os_tick_i),
      .rxd_s_i   (rxd_s),
      .par_en_i  (par_mode_i[1]),
      .par_odd_i (par_mode_i[0]),
      .dbl_i     (dbl_spd_i),
      .done_o    (frm_done),
      .data_o    (frm_data),
      .ferr_o    (frm_ferr),
      .perr_o    (frm_perr)
   );

   uart_rx_fifo #(.WIDTH(EW), .DEPTH(BUF_DEPTH)) i_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (~rx_en_i),
      .push_i  (frm_done),
      .din_i   ({frm_ferr, frm_perr, frm_data}),
      .pop_i   (pop_i),
      .head_o  (head),
      .valid_o (buf_valid),
      .ovr_o   (stat_ovr_o)
   );

   assign stat_valid_o = buf_valid;
   assign stat_frame_o = buf_valid & head[EW-1];
   assign stat_par_o   = buf_valid & head[EW-2];
   assign data_o       = buf_valid ? head[DATA_W-1:0] : '0;

endmodule

// File: rtl/uart_rx_flagbuf_chk.sv
module uart_rx_flagbuf_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_en_i,
   input logic              par_en,
   input logic              pop_i,
   input logic              stat_valid_o,
   input logic              stat_frame_o,
   input logic              stat_par_o,
   input logic              stat_ovr_o,
   input logic [DATA_W-1:0] data_o,
   input logic              frm_done,
   input logic              frm_perr
);

   // R1
   empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_valid_o |-> (!stat_frame_o && !stat_par_o && !stat_ovr_o && data_o == '0));

   // R7
   no_parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_done && !par_en) |-> !frm_perr);

   // R9
   head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en_i && stat_valid_o && !pop_i) |=> (stat_valid_o && $stable(data_o)));

   // R10
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en_i && stat_ovr_o && !pop_i) |=> stat_ovr_o);

   // R10
   ovr_pop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en_i && stat_valid_o && pop_i) |=> !stat_ovr_o);

   // R11
   disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en_i |=> (!stat_valid_o && !stat_ovr_o));

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done |=> !frm_done);

endmodule

bind uart_rx_flagbuf uart_rx_flagbuf_chk #(.DATA_W(DATA_W)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rx_en_i      (rx_en_i),
   .par_en       (par_mode_i[1]),
   .pop_i        (pop_i),
   .stat_valid_o (stat_valid_o),
   .stat_frame_o (stat_frame_o),
   .stat_par_o   (stat_par_o),
   .stat_ovr_o   (stat_ovr_o),
   .data_o       (data_o),
   .frm_done     (frm_done),
   .frm_perr     (frm_perr)
);

// File: tb/test_uart_rx_flagbuf.sv
`timescale 1ns/1ps
module test_uart_rx_flagbuf;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic       tick = 1'b0;
   logic       en = 1'b0;
   logic [1:0] pmode = 2'b00;
   logic       dbl = 1'b0;
   logic       pop = 1'b0;
   logic       st_valid, st_frame, st_par, st_ovr;
   logic [7:0] dout;

   int nchk = 0;
   int nerr = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;
   always @(negedge clk) tick = ~tick;

   uart_rx_flagbuf i_uart_rx_flagbuf (
      .clk          (clk),
      .rst_n        (rst_n),
      .rxd_i        (rxd),
      .os_tick_i    (tick),
      .rx_en_i      (en),
      .par_mode_i   (pmode),
      .dbl_spd_i    (dbl),
      .pop_i        (pop),
      .stat_valid_o (st_valid),
      .stat_frame_o (st_frame),
      .stat_par_o   (st_par),
      .stat_ovr_o   (st_ovr),
      .data_o       (dout)
   );

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic par_bit(input logic [7:0] d, input logic odd);
      return (^d) ^ odd;
   endfunction

   task automatic drive_bit(input logic v, input int bc, input bit glitch);
      rxd = v;
      if (glitch) begin
         wait_cyc(bc / 2);
         rxd = ~v;
         wait_cyc(2);
         rxd = v;
         wait_cyc(bc / 2 - 2);
      end else begin
         wait_cyc(bc);
      end
   endtask

   task automatic send_frame(input logic [7:0] d, input bit pe, input bit po,
                             input bit bad_par, input bit bad_stop,
                             input bit dspd, input bit glitch);
      int bc;
      bc    = dspd ? 16 : 32;
      pmode = {pe, po};
      dbl   = dspd;
      drive_bit(1'b0, bc, 1'b0);
      for (int i = 0; i < 8; i++) drive_bit(d[i], bc, glitch && (i == 3));
      if (pe) drive_bit(par_bit(d, po) ^ bad_par, bc, 1'b0);
      drive_bit(~bad_stop, bc, 1'b0);
      rxd = 1'b1;
      wait_cyc(bad_stop ? 3 * bc : bc);
   endtask

   task automatic do_pop();
      pop = 1'b1;
      wait_cyc(1);
      pop = 1'b0;
   endtask

   task automatic chk_head(input string tag, input logic [7:0] d, input logic fe, input logic pe_exp);
      chk({tag, " valid"}, st_valid, 1);
      chk({tag, " data"},  dout, d);
      chk({tag, " frame"}, st_frame, fe);
      chk({tag, " parity"}, st_par, pe_exp);
   endtask

   initial begin : p_main
      logic [7:0] d;
      logic [31:0] r;
      bit pe, po, bp, bs, ds, gl;
      void'($urandom(32'd20240611));

      wait_cyc(3);
      // R1: reset state
      chk("R1 valid", st_valid, 0);
      chk("R1 ovr", st_ovr, 0);
      chk("R1 frame", st_frame, 0);
      chk("R1 parity", st_par, 0);
      chk("R1 data", dout, 0);
      rst_n = 1'b1;
      en    = 1'b1;
      wait_cyc(4);
      chk("R1 after release", st_valid, 0);

      // R2: normal speed, no parity
      send_frame(8'hA5, 0, 0, 0, 0, 0, 0);
      chk_head("R2 16x", 8'hA5, 0, 0);
      do_pop();
      chk("R1 empty after pop", st_valid, 0);

      // R3: double speed
      send_frame(8'h3C, 0, 0, 0, 0, 1, 0);
      chk_head("R3 8x", 8'h3C, 0, 0);
      do_pop();
      send_frame(8'h81, 0, 0, 0, 0, 1, 0);
      chk_head("R3 8x second", 8'h81, 0, 0);
      do_pop();

      // R4: one-sample spike inside a data bit
      send_frame(8'h00, 0, 0, 0, 0, 0, 1);
      chk_head("R4 spike low bit", 8'h00, 0, 0);
      do_pop();
      send_frame(8'hFF, 0, 0, 0, 0, 1, 1);
      chk_head("R4 spike high bit", 8'hFF, 0, 0);
      do_pop();

      // R5: short low pulse is not a start bit
      rxd = 1'b0;
      wait_cyc(8);
      rxd = 1'b1;
      wait_cyc(96);
      chk("R5 glitch start stores nothing", st_valid, 0);
      send_frame(8'h5A, 0, 0, 0, 0, 0, 0);
      chk_head("R5 frame after glitch", 8'h5A, 0, 0);
      do_pop();

      // R6: parity even/odd good and bad
      send_frame(8'h07, 1, 0, 0, 0, 0, 0);
      chk_head("R6 even good", 8'h07, 0, 0);
      do_pop();
      send_frame(8'h07, 1, 1, 0, 0, 0, 0);
      chk_head("R6 odd good", 8'h07, 0, 0);
      do_pop();
      send_frame(8'hC3, 1, 0, 1, 0, 1, 0);
      chk_head("R6 even bad", 8'hC3, 0, 1);
      do_pop();
      send_frame(8'hC3, 1, 1, 1, 0, 0, 0);
      chk_head("R6 odd bad", 8'hC3, 0, 1);
      do_pop();

      // R7: parity disabled, odd weight byte, no parity bit on line
      send_frame(8'h01, 0, 1, 0, 0, 0, 0);
      chk_head("R7 parity off", 8'h01, 0, 0);
      do_pop();

      // R8: stop bit low
      send_frame(8'h96, 0, 0, 0, 1, 0, 0);
      chk_head("R8 frame error", 8'h96, 1, 0);
      do_pop();
      chk("R8 nothing extra stored", st_valid, 0);

      // R9 / R10: ordering, per-entry flags, overrun
      send_frame(8'h11, 1, 0, 1, 0, 0, 0);
      send_frame(8'h22, 1, 0, 0, 1, 0, 0);
      chk("R10 no ovr at two entries", st_ovr, 0);
      send_frame(8'h33, 1, 0, 0, 0, 0, 0);
      chk("R10 ovr set", st_ovr, 1);
      chk_head("R9 head is first", 8'h11, 0, 1);
      send_frame(8'h44, 1, 0, 0, 0, 0, 0);
      chk("R10 ovr held", st_ovr, 1);
      chk("R10 head unchanged while ovr", dout, 8'h11);
      do_pop();
      chk("R10 ovr cleared by pop", st_ovr, 0);
      chk_head("R9 second entry flags", 8'h22, 1, 0);
      do_pop();
      chk("R10 dropped frames absent", st_valid, 0);

      // R11: disable flushes buffer and aborts frame
      send_frame(8'h6E, 0, 0, 0, 0, 0, 0);
      chk("R11 buffered before disable", st_valid, 1);
      pmode = 2'b00;
      dbl   = 1'b0;
      drive_bit(1'b0, 32, 1'b0);
      drive_bit(1'b1, 32, 1'b0);
      drive_bit(1'b0, 16, 1'b0);
      en = 1'b0;
      wait_cyc(1);
      chk("R11 valid flushed", st_valid, 0);
      chk("R11 data flushed", dout, 0);
      rxd = 1'b1;
      wait_cyc(40);
      en = 1'b1;
      wait_cyc(4);
      send_frame(8'hB7, 0, 0, 0, 0, 0, 0);
      chk_head("R11 clean after re-enable", 8'hB7, 0, 0);
      do_pop();

      // random mix
      for (int i = 0; i < 30; i++) begin
         r  = $urandom;
         d  = r[7:0];
         pe = r[8];
         po = r[9];
         bp = r[10] & r[11];
         bs = r[12] & r[13];
         ds = r[14];
         gl = r[15];
         send_frame(d, pe, po, bp, bs, ds, gl);
         chk_head(pe ? "R6 random" : "R2 random", d, bs, pe & bp);
         do_pop();
         chk("R9 random empty", st_valid, 0);
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin : p_watchdog
      repeat (180000) @(posedge clk);
      if (!finished) begin
         nerr++;
         $display("FAIL watchdog R2: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

endmodule